// File: doc/BRIEF.md
# Processor mode and privilege controller

This block keeps track of whether a small processor core is running ordinary code (Thread mode) or servicing an exception (Handler mode). It also holds a one-bit thread privilege control value, and from the mode and that bit it derives the privilege that currently applies. Exception entry, exception return and supervisor-call strobes drive a two-state machine. A control-register port lets software read the privilege bit at any privilege level, but only privileged code can change it.

Each bus access request passes through a region guard. The guard refuses unprivileged accesses to three protected system ranges: the system timer, the interrupt controller and the system control block. A refused access gets no grant and zero read data, and it raises a one-cycle fault pulse. Permitted accesses pass through unchanged.

The states are `ST_THREAD` and `ST_HANDLER`. These transitions are named:
- `take_exception`: Thread to Handler, on exception entry or a supervisor call.
- `nest`: Handler stays in Handler, on entry or a supervisor call.
- `exc_done`: Handler to Thread, on exception return with no entry and no supervisor call.
- `idle`: the state is held when no strobe is active.

Top module: `exec_priv_ctrl`

## Requirements
- R1: While reset is held and after it is released, the block is in Thread mode (`mode_o`=0). The control bit is 0 (privileged), so `priv_o`=1 and `ctl_rd_data_o`=0.
- R2: An exception entry strobe puts the block in Handler mode (`mode_o`=1) on the next cycle. This holds even if exception return is asserted in the same cycle.
- R3: In Handler mode, an exception return with no entry and no supervisor call in the same cycle puts the block back in Thread mode on the next cycle.
- R4: In Handler mode, `priv_o` is 1 whatever value the control bit holds.
- R5: In Thread mode, `priv_o` is the inverse of control bit 0. A value of 0 means privileged and 1 means unprivileged.
- R6: A control write made while `priv_o`=1 loads `ctl_wdata_i[0]` into the control bit on the next cycle. All other data bits are discarded.
- R7: A control write made while `priv_o`=0 leaves the control bit unchanged. It raises `wr_ignored_o` for exactly the next cycle.
- R8: A supervisor-call strobe puts the block in Handler mode on the next cycle. Unprivileged Thread code therefore reaches privileged execution this way.
- R9: Some accesses are refused: those made while `priv_o`=0 to an address inside 0xE000E010..0xE000E01F, 0xE000E100..0xE000E4EF or 0xE000ED00..0xE000ED8F (both bounds included). A refused access gets `acc_grant_o`=0 and `acc_rdata_o`=0 in the same cycle, and `acc_fault_o`=1 on the next cycle. It changes neither the mode nor the control bit.
- R10: Any other access is passed through: `acc_grant_o`=`acc_req_i`, `acc_rdata_o`=`acc_rdata_i`, and no fault follows.
- R11: `ctl_rd_data_o` returns the control bit in bit 0 and zeros in all other bits, at every privilege level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_enter_i | input | 1 | Exception entry strobe |
| exc_return_i | input | 1 | Exception return strobe |
| svc_req_i | input | 1 | Supervisor-call strobe |
| ctl_wr_i | input | 1 | Control register write enable |
| ctl_wdata_i | input | DATA_W | Control register write data |
| ctl_rd_data_o | output | DATA_W | Control register read value |
| acc_req_i | input | 1 | Bus access request |
| acc_addr_i | input | ADDR_W | Bus access address |
| acc_rdata_i | input | DATA_W | Read data from the addressed target |
| acc_grant_o | output | 1 | Access allowed |
| acc_rdata_o | output | DATA_W | Read data returned to the requester |
| mode_o | output | 1 | 0 = Thread, 1 = Handler |
| priv_o | output | 1 | Effective privilege (1 = privileged) |
| wr_ignored_o | output | 1 | One-cycle pulse after a refused control write |
| acc_fault_o | output | 1 | One-cycle pulse after a refused access |

## Verification
The hardest situation to reach is unprivileged Thread code that touches a protected range exactly at its first or last address. A supervisor call or exception in the same cycle must not disturb the refusal. To get there, the control bit must first be set while privileged, and the block must then return from any exception.

The stimulus has a directed opening that walks this path. It is followed by random cycles in which addresses are drawn around every region bound, with entry, return, supervisor-call and control-write strobes mixed. Each result is compared against a bench reference model.

// File: rtl/priv_pkg.sv
package priv_pkg;
    typedef enum logic [0:0] {
        ST_THREAD  = 1'b0,
        ST_HANDLER = 1'b1
    } exec_mode_t;

    localparam int unsigned NUM_SYS_RGN = 3;
endpackage

// File: rtl/mode_fsm.sv
module mode_fsm
    import priv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       exc_enter_i,
    input  logic       exc_return_i,
    input  logic       svc_req_i,
    output exec_mode_t state_o
);
    exec_mode_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_THREAD;
        else        state_q <= state_d;
    end

    // next state: entry and supervisor call win over return
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_THREAD: begin
                if (exc_enter_i || svc_req_i) state_d = ST_HANDLER;      // take_exception
            end
            ST_HANDLER: begin
                if (exc_enter_i || svc_req_i) state_d = ST_HANDLER;      // nest
                else if (exc_return_i)        state_d = ST_THREAD;       // exc_done
            end
            default: state_d = ST_THREAD;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/ctl_reg.sv
module ctl_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic wbit_i,
    input  logic priv_i,
    output logic unpriv_o,
    output logic ignored_o
);
    logic bit_q, ign_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
            ign_q <= 1'b0;
        end else begin
            ign_q <= wr_i && !priv_i;
            if (wr_i && priv_i) bit_q <= wbit_i;
        end
    end

    assign unpriv_o  = bit_q;
    assign ignored_o = ign_q;
endmodule

// File: rtl/region_guard.sv
module region_guard #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned NRGN   = 3,
    parameter logic [ADDR_W-1:0] RGN_LO [NRGN] = '{default: '0},
    parameter logic [ADDR_W-1:0] RGN_HI [NRGN] = '{default: '0}
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);
    logic [NRGN-1:0] hit_vec;

    for (genvar g = 0; g < NRGN; g++) begin : g_rgn
        assign hit_vec[g] = (addr_i >= RGN_LO[g]) && (addr_i <= RGN_HI[g]);
    end

    assign hit_o = |hit_vec;
endmodule

// File: rtl/exec_priv_ctrl.sv
module exec_priv_ctrl
    import priv_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter logic [ADDR_W-1:0] SYS_LO [NUM_SYS_RGN] = '{32'hE000_E010, 32'hE000_E100, 32'hE000_ED00},
    parameter logic [ADDR_W-1:0] SYS_HI [NUM_SYS_RGN] = '{32'hE000_E01F, 32'hE000_E4EF, 32'hE000_ED8F}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_enter_i,
    input  logic              exc_return_i,
    input  logic              svc_req_i,
    input  logic              ctl_wr_i,
    input  logic [DATA_W-1:0] ctl_wdata_i,
    output logic [DATA_W-1:0] ctl_rd_data_o,
    input  logic              acc_req_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic [DATA_W-1:0] acc_rdata_i,
    output logic              acc_grant_o,
    output logic [DATA_W-1:0] acc_rdata_o,
    output logic              mode_o,
    output logic              priv_o,
    output logic              wr_ignored_o,
    output logic              acc_fault_o
);
    exec_mode_t state;
    logic       unpriv_bit;
    logic       priv_eff;
    logic       sys_hit;
    logic       refuse;
    logic       fault_q;

    mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .exc_enter_i (exc_enter_i),
        .exc_return_i(exc_return_i),
        .svc_req_i   (svc_req_i),
        .state_o     (state)
    );

    ctl_reg u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (ctl_wr_i),
        .wbit_i   (ctl_wdata_i[0]),
        .priv_i   (priv_eff),
        .unpriv_o (unpriv_bit),
        .ignored_o(wr_ignored_o)
    );

    region_guard #(
        .ADDR_W(ADDR_W),
        .NRGN  (NUM_SYS_RGN),
        .RGN_LO(SYS_LO),
        .RGN_HI(SYS_HI)
    ) u_guard (
        .addr_i(acc_addr_i),
        .hit_o (sys_hit)
    );

    // output process: privilege, access gating, read value
    always_comb begin
        unique case (state)
            ST_HANDLER: priv_eff = 1'b1;
            ST_THREAD:  priv_eff = !unpriv_bit;
            default:    priv_eff = 1'b1;
        endcase
        refuse        = acc_req_i && sys_hit && !priv_eff;
        acc_grant_o   = acc_req_i && !refuse;
        acc_rdata_o   = refuse ? '0 : acc_rdata_i;
        ctl_rd_data_o = {{(DATA_W-1){1'b0}}, unpriv_bit};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fault_q <= 1'b0;
        else        fault_q <= refuse;
    end

    assign mode_o      = (state == ST_HANDLER);
    assign priv_o      = priv_eff;
    assign acc_fault_o = fault_q;
endmodule

// File: rtl/exec_priv_ctrl_chk.sv
module exec_priv_ctrl_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exc_enter_i,
    input logic              exc_return_i,
    input logic              svc_req_i,
    input logic              ctl_wr_i,
    input logic [DATA_W-1:0] ctl_wdata_i,
    input logic [DATA_W-1:0] ctl_rd_data_o,
    input logic              acc_req_i,
    input logic              acc_grant_o,
    input logic [DATA_W-1:0] acc_rdata_o,
    input logic              mode_o,
    input logic              priv_o,
    input logic              wr_ignored_o,
    input logic              acc_fault_o
);
    a_r2_entry_handler: assert property (@(posedge clk) disable iff (!rst_n)
        exc_enter_i |=> mode_o);

    a_r3_return_thread: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o && exc_return_i && !exc_enter_i && !svc_req_i) |=> !mode_o);

    a_r4_handler_priv: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o |-> priv_o);

    a_r6_priv_write: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_i && priv_o) |=> (ctl_rd_data_o[0] == $past(ctl_wdata_i[0])));

    a_r7_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_i && !priv_o) |=> (wr_ignored_o && $stable(ctl_rd_data_o)));

    a_r8_svc_handler: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req_i |=> mode_o);

    a_r9_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req_i && !acc_grant_o) |=> acc_fault_o);

    a_r9_refused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req_i && !acc_grant_o) |-> (acc_rdata_o == '0 && !priv_o));

    a_r10_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
        acc_fault_o |-> $past(acc_req_i && !acc_grant_o));

    a_r11_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd_data_o[DATA_W-1:1] == '0);
endmodule

bind exec_priv_ctrl exec_priv_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .exc_enter_i  (exc_enter_i),
    .exc_return_i (exc_return_i),
    .svc_req_i    (svc_req_i),
    .ctl_wr_i     (ctl_wr_i),
    .ctl_wdata_i  (ctl_wdata_i),
    .ctl_rd_data_o(ctl_rd_data_o),
    .acc_req_i    (acc_req_i),
    .acc_grant_o  (acc_grant_o),
    .acc_rdata_o  (acc_rdata_o),
    .mode_o       (mode_o),
    .priv_o       (priv_o),
    .wr_ignored_o (wr_ignored_o),
    .acc_fault_o  (acc_fault_o)
);

// File: tb/exec_priv_ctrl_tb_top.sv
`timescale 1ns/1ps
module exec_priv_ctrl_tb_top;
    localparam int unsigned AW = 32;
    localparam int unsigned DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          exc_enter = 1'b0, exc_return = 1'b0, svc_req = 1'b0, ctl_wr = 1'b0;
    logic [DW-1:0] ctl_wdata = '0, ctl_rd;
    logic          acc_req = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [DW-1:0] acc_rdata_in = '0, acc_rdata_out;
    logic          acc_grant, mode, priv, wr_ign, acc_fault;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // reference state
    bit m_handler = 1'b0;
    bit m_ctl     = 1'b0;
    bit m_ign     = 1'b0;
    bit m_fault   = 1'b0;

    always #10 clk = ~clk;

    exec_priv_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .exc_enter_i(exc_enter), .exc_return_i(exc_return), .svc_req_i(svc_req),
        .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata), .ctl_rd_data_o(ctl_rd),
        .acc_req_i(acc_req), .acc_addr_i(acc_addr), .acc_rdata_i(acc_rdata_in),
        .acc_grant_o(acc_grant), .acc_rdata_o(acc_rdata_out),
        .mode_o(mode), .priv_o(priv), .wr_ignored_o(wr_ign), .acc_fault_o(acc_fault)
    );

    function automatic bit in_sys(input logic [AW-1:0] a);
        return (a >= 32'hE000_E010 && a <= 32'hE000_E01F) ||
               (a >= 32'hE000_E100 && a <= 32'hE000_E4EF) ||
               (a >= 32'hE000_ED00 && a <= 32'hE000_ED8F);
    endfunction

    function automatic bit exp_priv();
        return m_handler || !m_ctl;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_regs();
        chk(mode == m_handler, "R2/R3/R8 mode", DW'(mode), DW'(m_handler));
        chk(priv == exp_priv(), m_handler ? "R4 priv" : "R5 priv", DW'(priv), DW'(exp_priv()));
        chk(ctl_rd == DW'(m_ctl), "R11/R6 ctl read", ctl_rd, DW'(m_ctl));
        chk(wr_ign == m_ign, "R7 wr_ignored", DW'(wr_ign), DW'(m_ign));
        chk(acc_fault == m_fault, "R9/R10 fault", DW'(acc_fault), DW'(m_fault));
    endtask

    // drive at negedge, check comb outputs, clock, update model, check regs
    task automatic step(input bit en, input bit rt, input bit sv, input bit wr,
                        input logic [DW-1:0] wd, input bit rq,
                        input logic [AW-1:0] ad, input logic [DW-1:0] rd);
        bit blk;
        exc_enter = en; exc_return = rt; svc_req = sv; ctl_wr = wr;
        ctl_wdata = wd; acc_req = rq; acc_addr = ad; acc_rdata_in = rd;
        #2;
        blk = rq && in_sys(ad) && !exp_priv();
        chk(acc_grant == (rq && !blk), blk ? "R9 grant" : "R10 grant", DW'(acc_grant), DW'(rq && !blk));
        chk(acc_rdata_out == (blk ? '0 : rd), blk ? "R9 rdata" : "R10 rdata", acc_rdata_out, blk ? '0 : rd);
        @(posedge clk);
        m_fault = blk;
        m_ign   = wr && !exp_priv();
        if (wr && exp_priv()) m_ctl = wd[0];
        if (en || sv) m_handler = 1'b1;
        else if (m_handler && rt) m_handler = 1'b0;
        @(negedge clk);
        check_regs();
    endtask

    function automatic logic [AW-1:0] pick_addr();
        logic [AW-1:0] b [6] = '{32'hE000_E010, 32'hE000_E01F, 32'hE000_E100,
                                 32'hE000_E4EF, 32'hE000_ED00, 32'hE000_ED8F};
        int unsigned k = $urandom_range(0, 9);
        if (k < 6) begin
            int unsigned s = $urandom_range(0, 2);
            return (s == 0) ? b[k] : (s == 1) ? b[k] - 1 : b[k] + 1;
        end
        return $urandom();
    endfunction

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R1: reset values while reset held
        chk(mode == 1'b0, "R1 mode in reset", DW'(mode), 0);
        chk(priv == 1'b1, "R1 priv in reset", DW'(priv), 1);
        chk(ctl_rd == '0, "R1 ctl in reset", ctl_rd, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_regs();
        // privileged write sets unprivileged (R6), upper bits ignored
        step(0,0,0,1,32'hFFFF_FFF1,0,'0,'0);
        // unprivileged write ignored (R7)
        step(0,0,0,1,32'h0,0,'0,'0);
        // unprivileged access at region bounds refused (R9)
        step(0,0,0,0,'0,1,32'hE000_ED00,32'hDEAD_BEEF);
        step(0,0,0,0,'0,1,32'hE000_E01F,32'h1234_5678);
        // just outside a region passes (R10)
        step(0,0,0,0,'0,1,32'hE000_ED90,32'hCAFE_F00D);
        // supervisor call from unprivileged Thread (R8), with refused access same cycle
        step(0,0,1,0,'0,1,32'hE000_E100,32'hAAAA_5555);
        // Handler: privileged although ctl bit set (R4); access granted (R10)
        step(0,0,0,0,'0,1,32'hE000_E100,32'h1111_2222);
        // return to Thread (R3)
        step(0,1,0,0,'0,0,'0,'0);
        // entry and return together: entry wins (R2)
        step(1,1,0,0,'0,0,'0,'0);
        step(0,1,0,1,32'h0,0,'0,'0);
        // random phase
        for (int i = 0; i < 3000; i++) begin
            step($urandom_range(0,7) == 0, $urandom_range(0,3) == 0, $urandom_range(0,11) == 0,
                 $urandom_range(0,3) == 0, $urandom(), $urandom_range(0,1) == 1,
                 pick_addr(), $urandom());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule